// File: doc/BRIEF.md
# Vectored Eight-Line Interrupt Controller

The block sits between eight interrupt-raising devices and an 8080-style processor. Each device holds its own latched request line high until it is told the request has been serviced. The controller merges these requests into one interrupt line toward the processor, gated by the processor's interrupt-enable status. When the processor answers with its active-low acknowledge strobe, the controller picks the highest-numbered pending line. It then places a one-byte restart instruction on the data bus, whose restart number equals the chosen line. Once the acknowledge strobe goes away, it returns a one-clock acknowledge pulse to that device so the device can drop its request.

Bus release outside the acknowledge cycle is modelled by a separate output-enable signal. While that enable is low, the byte output rests at 0xFF.

The control is a three-state machine:
- `ST_IDLE` watches the requests and drives the interrupt line. It leaves for `ST_GRANT` on the first clock edge at which `ack_n` is sampled low, and at that edge the winning line is captured.
- `ST_GRANT` enables the bus and presents the opcode. It leaves for `ST_RETIRE` on the first edge at which `ack_n` is sampled high.
- `ST_RETIRE` pulses the device acknowledge for one clock and always returns to `ST_IDLE`.

Top module: `irqv_ctrl`

## Requirements
- R1: After reset, `irq` is 0, `data_oe` is 0, `data_out` is 0xFF and `dev_ack` is 0.
- R2: In `ST_IDLE`, `irq` is 1 exactly when `cpu_ie` is 1 and at least one bit of `req` is 1.
- R3: When several request bits are 1, the highest-numbered one is the one serviced.
- R4: The serviced line is captured at the first clock edge where `ack_n` is sampled low. Request changes after that edge do not alter the presented byte or the acknowledged line.
- R5: The opcode for line n is 0xC7 OR (n << 3), so bits 5:3 carry n and bits 7:6 and 2:0 are all ones (line 0 gives 0xC7, line 7 gives 0xFF).
- R6: `data_oe` is 1 from the clock after `ack_n` is first sampled low until the edge at which `ack_n` is sampled high again. While `data_oe` is 0, `data_out` is 0xFF.
- R7: One clock after the acknowledge cycle ends, `dev_ack` bit n of the serviced line is 1 for exactly one clock. At most one bit of `dev_ack` is ever set.
- R8: If no request was pending at the capture edge, the presented byte is 0xFF and no `dev_ack` bit is pulsed.
- R9: `irq` is held at 0 while in `ST_GRANT` and `ST_RETIRE`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Latched device requests, bit n is line n |
| cpu_ie | input | 1 | Processor interrupt-enable status |
| ack_n | input | 1 | Processor interrupt acknowledge, active low |
| irq | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Restart opcode, 0xFF when not enabled |
| data_oe | output | 1 | Data bus drive enable |
| dev_ack | output | 8 | One-clock per-line service acknowledge |

## Verification
The main function is exercised with a lone request on a middle line and a lone request on line 0. A lone request shows that the opcode field and the acknowledge bit follow the line number, and line 0 exposes a missing OR of the constant bits. Three simultaneous requests are then drained one acknowledge cycle at a time, which separates highest-wins from lowest-wins or first-come ordering and shows that each pulse clears only its own line. A higher line raised during a running acknowledge cycle tells a captured winner apart from a live one. An acknowledge with nothing pending, and a pending request with the enable low, separate the empty-grant byte and the interrupt gating from the normal path.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    localparam int unsigned LINES     = 8;
    localparam int unsigned IDX_W     = $clog2(LINES);
    localparam logic [7:0]  IDLE_BYTE = 8'hFF;
    localparam logic [7:0]  RST_BASE  = 8'hC7;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_RETIRE = 2'd2
    } irqv_state_t;

    // Restart opcode: the line number lands in bits 5:3
    function automatic logic [7:0] rst_opcode(input logic [IDX_W-1:0] n);
        return RST_BASE | {2'b00, n, 3'b000};
    endfunction

endpackage

// File: rtl/irqv_prio.sv
module irqv_prio
    import irqv_pkg::*;
#(
    parameter int unsigned N   = LINES,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] top_idx
);
    // Highest-numbered pending line wins: later loop iterations override
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (req[i]) top_idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/irqv_fsm.sv
module irqv_fsm
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_n,
    input  logic             cpu_ie,
    input  logic             any_req,
    input  logic [IDX_W-1:0] top_idx,
    output logic             irq,
    output logic [7:0]       byte_out,
    output logic             bus_en,
    output logic             retire,
    output logic [IDX_W-1:0] win_idx
);
    irqv_state_t state, nxt;
    logic        win_vld;

    // State register plus the captured winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            win_idx <= '0;
            win_vld <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && !ack_n) begin
                win_idx <= top_idx;
                win_vld <= any_req;
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!ack_n) nxt = ST_GRANT;
            ST_GRANT:  if (ack_n)  nxt = ST_RETIRE;
            ST_RETIRE: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq      = 1'b0;
        bus_en   = 1'b0;
        byte_out = IDLE_BYTE;
        retire   = 1'b0;
        unique case (state)
            ST_IDLE:   irq = cpu_ie & any_req;
            ST_GRANT: begin
                bus_en   = 1'b1;
                byte_out = win_vld ? rst_opcode(win_idx) : IDLE_BYTE;
            end
            ST_RETIRE: retire = win_vld;
            default: ;
        endcase
    end
endmodule

// File: rtl/irqv_ackdec.sv
module irqv_ackdec
    import irqv_pkg::*;
#(
    parameter int unsigned N   = LINES,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          pulse,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  ack
);
    for (genvar g = 0; g < int'(N); g++) begin : g_line
        assign ack[g] = pulse && (idx == IW'(g));
    end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
    import irqv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req,
    input  logic             cpu_ie,
    input  logic             ack_n,
    output logic             irq,
    output logic [7:0]       data_out,
    output logic             data_oe,
    output logic [LINES-1:0] dev_ack
);
    logic             any_req;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] win_idx;
    logic             retire;

    irqv_prio #(.N(LINES)) u_prio (
        .req     (req),
        .any     (any_req),
        .top_idx (top_idx)
    );

    irqv_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_n    (ack_n),
        .cpu_ie   (cpu_ie),
        .any_req  (any_req),
        .top_idx  (top_idx),
        .irq      (irq),
        .byte_out (data_out),
        .bus_en   (data_oe),
        .retire   (retire),
        .win_idx  (win_idx)
    );

    irqv_ackdec #(.N(LINES)) u_dec (
        .pulse (retire),
        .idx   (win_idx),
        .ack   (dev_ack)
    );
endmodule

// File: rtl/irqv_ctrl_chk.sv
module irqv_ctrl_chk
    import irqv_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] req,
    input logic             cpu_ie,
    input logic             ack_n,
    input logic             irq,
    input logic [7:0]       data_out,
    input logic             data_oe,
    input logic [LINES-1:0] dev_ack
);
    // R2
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cpu_ie && (req != '0)));

    // R6
    idle_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> (data_out == IDLE_BYTE));

    // R6
    oe_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe) |-> !$past(ack_n));

    // R5
    opcode_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out[7:6] == 2'b11 && data_out[2:0] == 3'b111));

    // R7
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack));

    // R7
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != '0) |=> (dev_ack == '0));

    // R7
    ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != '0) |-> $past(data_oe));

    // R9
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe || dev_ack != '0) |-> !irq);
endmodule

bind irqv_ctrl irqv_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .cpu_ie   (cpu_ie),
    .ack_n    (ack_n),
    .irq      (irq),
    .data_out (data_out),
    .data_oe  (data_oe),
    .dev_ack  (dev_ack)
);

// File: tb/irqv_ctrl_bench.sv
`timescale 1ns/1ps
module irqv_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req;
    logic [7:0] set_mask = 8'h00;
    logic       cpu_ie = 1'b0;
    logic       ack_n = 1'b1;
    logic       irq;
    logic [7:0] data_out;
    logic       data_oe;
    logic [7:0] dev_ack;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    irqv_ctrl u_irqv_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .cpu_ie(cpu_ie), .ack_n(ack_n),
        .irq(irq), .data_out(data_out), .data_oe(data_oe), .dev_ack(dev_ack)
    );

    // Device model: latches raised lines, drops a line on its acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req <= 8'h00;
        else        req <= (req | set_mask) & ~dev_ack;
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic raise(input logic [7:0] m);
        @(negedge clk) set_mask = m;
        @(negedge clk) set_mask = 8'h00;
    endtask

    function automatic logic [7:0] op(input int n);
        return 8'hC7 | 8'(n << 3);
    endfunction

    // Full acknowledge cycle; inject raises lines while the grant is held
    task automatic ack_cycle(input string tag, input logic [7:0] exp_byte,
                             input logic [7:0] exp_ack, input logic [7:0] inject);
        @(negedge clk) ack_n = 1'b0;
        @(negedge clk);
        check({tag, " R6 oe"}, {7'd0, data_oe}, 8'h01);
        check({tag, " R5 byte"}, data_out, exp_byte);
        check({tag, " R9 irq low in grant"}, {7'd0, irq}, 8'h00);
        set_mask = inject;
        @(negedge clk);
        set_mask = 8'h00;
        check({tag, " R4 byte held"}, data_out, exp_byte);
        ack_n = 1'b1;
        @(negedge clk);
        check({tag, " R6 oe off"}, {7'd0, data_oe}, 8'h00);
        check({tag, " R6 idle byte"}, data_out, 8'hFF);
        check({tag, " R7 pulse"}, dev_ack, exp_ack);
        check({tag, " R9 irq low in retire"}, {7'd0, irq}, 8'h00);
        @(negedge clk);
        check({tag, " R7 pulse ends"}, dev_ack, 8'h00);
        check({tag, " R7 line cleared"}, req & exp_ack, 8'h00);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 oe", {7'd0, data_oe}, 8'h00);
        check("R1 byte", data_out, 8'hFF);
        check("R1 dev_ack", dev_ack, 8'h00);
    endtask

    task automatic t_single();
        raise(8'h04);
        check("R2 irq single", {7'd0, irq}, 8'h01);
        ack_cycle("single line2", op(2), 8'h04, 8'h00);
        check("R2 irq after drain", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_multi();
        raise(8'h52);
        ack_cycle("multi R3 line6", op(6), 8'h40, 8'h00);
        check("R2 irq remaining", {7'd0, irq}, 8'h01);
        ack_cycle("multi R3 line4", op(4), 8'h10, 8'h00);
        ack_cycle("multi R3 line1", op(1), 8'h02, 8'h00);
        check("R2 irq empty", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_gate();
        cpu_ie = 1'b0;
        raise(8'h20);
        check("R2 irq gated", {7'd0, irq}, 8'h00);
        cpu_ie = 1'b1;
        #1;
        check("R2 irq ungated", {7'd0, irq}, 8'h01);
        ack_cycle("gate line5", op(5), 8'h20, 8'h00);
    endtask

    task automatic t_freeze();
        raise(8'h08);
        ack_cycle("freeze R4 line3", op(3), 8'h08, 8'h80);
        check("R4 late line pending", req, 8'h80);
        ack_cycle("freeze line7", op(7), 8'h80, 8'h00);
    endtask

    task automatic t_empty();
        ack_cycle("empty R8", 8'hFF, 8'h00, 8'h00);
    endtask

    task automatic t_line0();
        raise(8'h01);
        ack_cycle("line0 R5", 8'hC7, 8'h01, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        cpu_ie = 1'b1;
        t_single();
        t_multi();
        t_gate();
        t_freeze();
        t_empty();
        t_line0();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule